// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller with Nibble-Decoded 13-Bit Instructions

This block is the test access port of a chip. It runs the standard sixteen-state test controller, stepped on the rising edge of the test clock by the mode-select input. It holds a 13-bit instruction, a one-bit bypass stage and a 32-bit identification word, and it steers the serial scan path between them and an external boundary register. The boundary register itself sits outside this block. The controller supplies its serial input, takes its serial output, and drives its capture, shift and update strobes, its select line and its test-mode line. A separate output tells the pad ring to float every functional output.

Only the low four bits of the instruction pick the operation. The upper nine bits are shifted and stored but do not affect the decode. Unknown codes behave as bypass and leave the pins in functional mode. The scan output changes on the falling edge of the test clock, and its enable is high only while an instruction or data scan is shifting. A low level on the active-low test reset at a rising clock edge returns the controller to its reset state. Holding mode-select high for five clocks does the same.

Top module: `tap_ctrl13`

## Requirements
- R1: The controller follows the standard sixteen-state test state machine on rising test-clock edges. From any state, five consecutive rising edges with tms high reach Test-Logic-Reset, and that state loads the reset instruction.
- R2: trst_n low at a rising tck edge puts the controller in Test-Logic-Reset. It loads the reset instruction: IDCODE (13'b0000000000010) when HAS_IDENT is 1, all ones otherwise. It clears tdo_en and pins_disable.
- R3: Capture-IR loads 13'b0000000000001 into the instruction shift stage. That value is shifted out on tdo least significant bit first.
- R4: In Shift-IR the stage shifts tdi in at the most significant end and shifts out at bit 0. The active instruction changes only in Update-IR or Test-Logic-Reset, so a shifted code has no effect while the controller is in Exit1-IR.
- R5: The active instruction's bits 3:0 select the operation: 0000 EXTEST, 0001 SAMPLE, 0010 IDCODE, 1011 HIGHZ. Every other nibble, and the 13-bit all-ones code, selects bypass. Bits 12:4 are ignored.
- R6: Under IDCODE, Capture-DR loads the identification word {ID_VERSION[3:0], ID_PART[15:0], 11'b00000001001, 1'b1}. Shift-DR sends it out on tdo least significant bit first.
- R7: Under any bypass-path instruction, the one-bit stage captures 0 in Capture-DR. In Shift-DR it delays tdi by exactly one clock on its way to tdo.
- R8: Under EXTEST or SAMPLE, bsr_select is 1, tdo carries bsr_so, and bsr_si equals tdi. bsr_capture, bsr_shift and bsr_update are high only in Capture-DR, Shift-DR and Update-DR respectively. bsr_mode is 1 only under EXTEST.
- R9: pins_disable is 1 only under HIGHZ, and then the data path is the bypass stage. Unlisted codes leave pins_disable and bsr_mode at 0.
- R10: tdo and tdo_en are updated on the falling tck edge. tdo_en is 1 only while the controller is in Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Active-low test reset, sampled on rising tck |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, updated on falling tck |
| tdo_en | output | 1 | Output enable for the tdo pad |
| bsr_si | output | 1 | Serial input to the external boundary register |
| bsr_so | input | 1 | Serial output from the external boundary register |
| bsr_select | output | 1 | Boundary register is the selected data path |
| bsr_capture | output | 1 | Boundary register capture strobe |
| bsr_shift | output | 1 | Boundary register shift strobe |
| bsr_update | output | 1 | Boundary register update strobe |
| bsr_mode | output | 1 | Boundary cells drive the pins (test mode) |
| pins_disable | output | 1 | Float all functional outputs |

## Verification
The assertions assume that trst_n, tms, tdi and bsr_so change only away from both tck edges. They also assume that trst_n is held low across at least one rising edge before the first scan, so the controller state and the falling-edge output registers are defined. The bench therefore moves every input three quarters of a period after a rising edge and keeps reset low for several clocks at the start. It mixes random 13-bit codes with codes whose low nibble is drawn from the listed operations under random upper bits. It adds directed walks through trst_n mid-scan, five-high tms escapes from inside an instruction scan, and a sample taken between the rising and falling edge to pin down when tdo_en moves.

// File: rtl/tap13_pkg.sv
// tap13_pkg: state encoding, decode result type and next-state function
// shared by the test access port controller modules.
// Assumes: instruction register of at least four bits; decode uses bits 3:0.
package tap13_pkg;

    typedef enum logic [3:0] {
        ST_TLR, ST_RTI,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {
        PATH_BYPASS   = 2'd0,
        PATH_IDENT    = 2'd1,
        PATH_BOUNDARY = 2'd2
    } dr_path_e;

    typedef struct packed {
        dr_path_e path;
        logic     ext_mode;
        logic     float_pins;
    } op_ctl_t;

    localparam logic [3:0] NIB_EXTEST = 4'h0;
    localparam logic [3:0] NIB_SAMPLE = 4'h1;
    localparam logic [3:0] NIB_IDENT  = 4'h2;
    localparam logic [3:0] NIB_FLOAT  = 4'hB;

    // Standard controller transition for one rising edge of the test clock.
    function automatic tap_state_e tap_next(input tap_state_e st, input logic m);
        tap_state_e nx;
        case (st)
            ST_TLR:    nx = m ? ST_TLR    : ST_RTI;
            ST_RTI:    nx = m ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: nx = m ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: nx = m ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  nx = m ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: nx = m ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: nx = m ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: nx = m ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: nx = m ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: nx = m ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: nx = m ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  nx = m ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: nx = m ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: nx = m ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: nx = m ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: nx = m ? ST_SEL_DR : ST_RTI;
            default:   nx = ST_TLR;
        endcase
        return nx;
    endfunction

endpackage

// File: rtl/tap13_fsm.sv
// tap13_fsm: sixteen-state test controller stepped by tms on rising tck.
// Assumes: trst_n is synchronous to tck and active low.
module tap13_fsm
    import tap13_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state
);

    localparam int unsigned ESCAPE_LEN = 5;
    localparam int unsigned RUN_W      = $clog2(ESCAPE_LEN + 1);

    // Advance the controller state, or force Test-Logic-Reset under reset.
    always_ff @(posedge tck) begin
        if (!trst_n) state <= ST_TLR;
        else         state <= tap_next(state, tms);
    end

    // Count consecutive tms-high edges (saturating) to check the escape rule.
    logic [RUN_W-1:0] tms_run;
    always_ff @(posedge tck) begin
        if (!trst_n)                             tms_run <= '0;
        else if (!tms)                           tms_run <= '0;
        else if (tms_run != RUN_W'(ESCAPE_LEN))  tms_run <= tms_run + 1'b1;
    end

    // R1: five rising edges with tms high always land in Test-Logic-Reset.
    a_r1_tms_escape: assert property (@(posedge tck) disable iff (!trst_n)
        (tms_run == RUN_W'(ESCAPE_LEN)) |-> (state == ST_TLR));

    // R1: leaving Test-Logic-Reset goes to Run-Test/Idle.
    a_r1_leave_reset: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_TLR && !tms) |=> (state == ST_RTI));

endmodule

// File: rtl/tap13_ir.sv
// tap13_ir: instruction shift stage, active instruction and nibble decode.
// Assumes: IR_LEN >= 4; the active instruction is replaced only in
// Update-IR or Test-Logic-Reset.
module tap13_ir
    import tap13_pkg::*;
#(
    parameter int unsigned IR_LEN    = 13,
    parameter bit          HAS_IDENT = 1'b1
) (
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tdi,
    input  tap_state_e state,
    output logic       ir_so,
    output op_ctl_t    ctl
);

    localparam logic [IR_LEN-1:0] CAPTURE_CODE = {{(IR_LEN-1){1'b0}}, 1'b1};
    localparam logic [IR_LEN-1:0] RESET_CODE   = HAS_IDENT ?
        {{(IR_LEN-4){1'b0}}, NIB_IDENT} : {IR_LEN{1'b1}};

    logic [IR_LEN-1:0] ir_sr;
    logic [IR_LEN-1:0] ir_q;

    // Instruction shift stage: fixed capture pattern, then shift toward bit 0.
    always_ff @(posedge tck) begin
        if (!trst_n)                ir_sr <= CAPTURE_CODE;
        else if (state == ST_CAP_IR) ir_sr <= CAPTURE_CODE;
        else if (state == ST_SH_IR)  ir_sr <= {tdi, ir_sr[IR_LEN-1:1]};
    end

    // Active instruction: reset code in Test-Logic-Reset, new code at Update-IR.
    always_ff @(posedge tck) begin
        if (!trst_n || state == ST_TLR) ir_q <= RESET_CODE;
        else if (state == ST_UPD_IR)    ir_q <= ir_sr;
    end

    assign ir_so = ir_sr[0];

    // Decode from the low nibble; the all-ones code is bypass outright.
    always_comb begin
        ctl = '{path: PATH_BYPASS, ext_mode: 1'b0, float_pins: 1'b0};
        if (!(&ir_q)) begin
            case (ir_q[3:0])
                NIB_EXTEST: ctl = '{path: PATH_BOUNDARY, ext_mode: 1'b1, float_pins: 1'b0};
                NIB_SAMPLE: ctl = '{path: PATH_BOUNDARY, ext_mode: 1'b0, float_pins: 1'b0};
                NIB_IDENT:  ctl.path = HAS_IDENT ? PATH_IDENT : PATH_BYPASS;
                NIB_FLOAT:  ctl.float_pins = 1'b1;
                default:    ctl.path = PATH_BYPASS;
            endcase
        end
    end

    // R3: Capture-IR leaves the fixed pattern in the shift stage.
    a_r3_capture_pattern: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_CAP_IR) |=> (ir_sr == CAPTURE_CODE));

    // R4: the active instruction moves only after Update-IR or Test-Logic-Reset.
    a_r4_update_only: assert property (@(posedge tck) disable iff (!trst_n)
        ($past(trst_n) && !$stable(ir_q)) |->
        ($past(state) == ST_UPD_IR || $past(state) == ST_TLR));

    // R9: floating pins and test mode never coincide.
    a_r9_float_vs_mode: assert property (@(posedge tck) disable iff (!trst_n)
        $onehot0({ctl.float_pins, ctl.ext_mode}));

    // R9: floating pins always routes through the bypass stage.
    a_r9_float_bypass: assert property (@(posedge tck) disable iff (!trst_n)
        ctl.float_pins |-> (ctl.path == PATH_BYPASS));

endmodule

// File: rtl/tap13_dr.sv
// tap13_dr: bypass stage, optional identification register and the
// data-path multiplexer that also folds in the external boundary output.
// Assumes: path is stable during a data scan (changes only at Update-IR).
module tap13_dr
    import tap13_pkg::*;
#(
    parameter bit          HAS_IDENT = 1'b1,
    parameter logic [31:0] ID_WORD   = 32'h0000_0013
) (
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tdi,
    input  tap_state_e state,
    input  dr_path_e   path,
    input  logic       bsr_so,
    output logic       dr_so
);

    localparam int unsigned ID_W = 32;

    logic bypass_q;
    logic id_bit;

    // One-bit bypass stage: captures 0, then passes tdi on each shift edge.
    always_ff @(posedge tck) begin
        if (!trst_n)                 bypass_q <= 1'b0;
        else if (state == ST_CAP_DR) bypass_q <= 1'b0;
        else if (state == ST_SH_DR)  bypass_q <= tdi;
    end

    generate
        if (HAS_IDENT) begin : g_ident
            logic [ID_W-1:0] id_sr;

            // Identification shift register: fixed word on capture, LSB out.
            always_ff @(posedge tck) begin
                if (!trst_n)                                        id_sr <= ID_WORD;
                else if (state == ST_CAP_DR && path == PATH_IDENT)  id_sr <= ID_WORD;
                else if (state == ST_SH_DR && path == PATH_IDENT)   id_sr <= {tdi, id_sr[ID_W-1:1]};
            end
            assign id_bit = id_sr[0];

            // R6: capture under IDCODE leaves the full identification word.
            a_r6_ident_capture: assert property (@(posedge tck) disable iff (!trst_n)
                (state == ST_CAP_DR && path == PATH_IDENT) |=> (id_sr == ID_WORD));
        end else begin : g_no_ident
            assign id_bit = 1'b0;
        end
    endgenerate

    // Select the serial output of the data register in use.
    always_comb begin
        case (path)
            PATH_IDENT:    dr_so = id_bit;
            PATH_BOUNDARY: dr_so = bsr_so;
            default:       dr_so = bypass_q;
        endcase
    end

    // R7: Capture-DR always clears the bypass stage.
    a_r7_bypass_zero: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_CAP_DR) |=> (bypass_q == 1'b0));

endmodule

// File: rtl/tap_ctrl13.sv
// tap_ctrl13: test access port controller top. Ties the state machine,
// instruction logic and data registers together, generates boundary
// register strobes and registers tdo/tdo_en on the falling tck edge.
// Assumes: inputs change away from tck edges; trst_n is active low and
// sampled on tck (rising edge for the core, falling edge for tdo).
module tap_ctrl13
    import tap13_pkg::*;
#(
    parameter int unsigned IR_LEN     = 13,
    parameter bit          HAS_IDENT  = 1'b1,
    parameter logic [3:0]  ID_VERSION = 4'h3,
    parameter logic [15:0] ID_PART    = 16'h05A7,
    parameter logic [10:0] ID_MAKER   = 11'b00000001001
) (
    input  logic tck,
    input  logic trst_n,
    input  logic tms,
    input  logic tdi,
    output logic tdo,
    output logic tdo_en,
    output logic bsr_si,
    input  logic bsr_so,
    output logic bsr_select,
    output logic bsr_capture,
    output logic bsr_shift,
    output logic bsr_update,
    output logic bsr_mode,
    output logic pins_disable
);

    localparam logic [31:0] ID_WORD = {ID_VERSION, ID_PART, ID_MAKER, 1'b1};

    tap_state_e state;
    op_ctl_t    ctl;
    logic       ir_so;
    logic       dr_so;

    tap13_fsm u_fsm (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .state  (state)
    );

    tap13_ir #(
        .IR_LEN    (IR_LEN),
        .HAS_IDENT (HAS_IDENT)
    ) u_ir (
        .tck    (tck),
        .trst_n (trst_n),
        .tdi    (tdi),
        .state  (state),
        .ir_so  (ir_so),
        .ctl    (ctl)
    );

    tap13_dr #(
        .HAS_IDENT (HAS_IDENT),
        .ID_WORD   (ID_WORD)
    ) u_dr (
        .tck    (tck),
        .trst_n (trst_n),
        .tdi    (tdi),
        .state  (state),
        .path   (ctl.path),
        .bsr_so (bsr_so),
        .dr_so  (dr_so)
    );

    // Boundary register controls follow the state while it is the path.
    assign bsr_select   = (ctl.path == PATH_BOUNDARY);
    assign bsr_capture  = bsr_select && (state == ST_CAP_DR);
    assign bsr_shift    = bsr_select && (state == ST_SH_DR);
    assign bsr_update   = bsr_select && (state == ST_UPD_DR);
    assign bsr_mode     = ctl.ext_mode;
    assign pins_disable = ctl.float_pins;
    assign bsr_si       = tdi;

    // Falling-edge output stage: drive tdo only while a scan is shifting.
    always_ff @(negedge tck) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo_en <= (state == ST_SH_IR) || (state == ST_SH_DR);
            tdo    <= (state == ST_SH_IR) ? ir_so :
                      (state == ST_SH_DR) ? dr_so : 1'b0;
        end
    end

    // R10: the pad is enabled only during Shift-IR or Shift-DR.
    a_r10_enable_window: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_en |-> (state == ST_SH_IR || state == ST_SH_DR));

    // R8: a boundary update strobe only ever follows an exit state.
    a_r8_update_after_exit: assert property (@(posedge tck) disable iff (!trst_n)
        bsr_update |-> ($past(state) == ST_EX1_DR || $past(state) == ST_EX2_DR));

endmodule

// File: tb/tap_ctrl13_test.sv
// tap_ctrl13_test: self-checking bench. Inputs move three quarters of a
// period after each rising edge; outputs are read at that same point.
module tap_ctrl13_test;

    localparam int TCK_PERIOD = 64;
    localparam int QTR        = TCK_PERIOD / 4;
    localparam logic [31:0] EXP_ID = {4'h3, 16'h05A7, 11'b00000001001, 1'b1};

    logic tck = 1'b0;
    logic trst_n, tms, tdi, bsr_so;
    logic tdo, tdo_en, bsr_si, bsr_select, bsr_capture, bsr_shift, bsr_update;
    logic bsr_mode, pins_disable;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    tap_ctrl13 uut (
        .tck          (tck),
        .trst_n       (trst_n),
        .tms          (tms),
        .tdi          (tdi),
        .tdo          (tdo),
        .tdo_en       (tdo_en),
        .bsr_si       (bsr_si),
        .bsr_so       (bsr_so),
        .bsr_select   (bsr_select),
        .bsr_capture  (bsr_capture),
        .bsr_shift    (bsr_shift),
        .bsr_update   (bsr_update),
        .bsr_mode     (bsr_mode),
        .pins_disable (pins_disable)
    );

    always #(TCK_PERIOD/2) tck = ~tck;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected data path: 0 bypass, 1 identification, 2 boundary.
    function automatic int exp_kind(input logic [12:0] c);
        if (&c) return 0;
        case (c[3:0])
            4'h0, 4'h1: return 2;
            4'h2:       return 1;
            default:    return 0;
        endcase
    endfunction

    function automatic logic exp_float(input logic [12:0] c);
        return (c[3:0] == 4'hB);
    endfunction

    function automatic logic exp_mode(input logic [12:0] c);
        return (c[3:0] == 4'h0);
    endfunction

    // One clock: set inputs, pass rising and falling edge, settle.
    task automatic tick(input logic m, input logic d);
        tms = m;
        tdi = d;
        @(posedge tck);
        @(negedge tck);
        #(QTR);
    endtask

    // From Run-Test/Idle: load an instruction, return to Run-Test/Idle.
    task automatic load_ir(input logic [12:0] code, input logic old_float,
                           output logic [12:0] cap);
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        check("R10 tdo_en in Shift-IR", tdo_en, 1);
        for (int i = 0; i < 13; i++) begin
            cap[i] = tdo;
            tick(i == 12, code[i]);
        end
        check("R4 no effect before Update-IR", pins_disable, old_float);
        tick(1, 0); tick(0, 0);
        check("R10 tdo_en off in idle", tdo_en, 0);
    endtask

    // From Run-Test/Idle: scan n data bits, return to Run-Test/Idle.
    task automatic scan_dr(input int n, input logic [63:0] din,
                           output logic [63:0] dout, input logic exp_bsr);
        dout = '0;
        tick(1, 0); tick(0, 0);
        check("R8 capture strobe", bsr_capture, exp_bsr);
        tick(0, 0);
        check("R8 shift strobe", bsr_shift, exp_bsr);
        for (int i = 0; i < n; i++) begin
            dout[i] = tdo;
            if (i == 0) check("R8 boundary serial in", bsr_si, tdi);
            tick(i == n - 1, din[i]);
        end
        tick(1, 0);
        check("R8 update strobe", bsr_update, exp_bsr);
        tick(0, 0);
    endtask

    // Load a code and verify decode outputs and the data path it selects.
    task automatic run_code(input logic [12:0] code, input logic old_float);
        logic [12:0] cap;
        logic [63:0] din, dout;
        int k;
        load_ir(code, old_float, cap);
        check("R3 capture pattern", {51'd0, cap}, 64'd1);
        check("R9 pins_disable", pins_disable, exp_float(code));
        check("R8 bsr_mode", bsr_mode, exp_mode(code));
        k = exp_kind(code);
        check("R5 boundary select", bsr_select, k == 2);
        din = {$urandom, $urandom};
        if (k == 1) begin
            scan_dr(32, din, dout, 0);
            check("R6 identification word", dout, {32'd0, EXP_ID});
        end else if (k == 0) begin
            scan_dr(16, din, dout, 0);
            check("R7 one-bit bypass delay", dout, {48'd0, din[14:0], 1'b0});
        end else begin
            bsr_so = din[40];
            scan_dr(12, din, dout, 1);
            check("R8 tdo follows bsr_so", dout, din[40] ? 64'hFFF : 64'h0);
        end
    endtask

    initial begin
        logic [12:0] cap;
        logic [63:0] dout;
        logic [12:0] code;
        void'($urandom(32'h1d5));
        trst_n = 1'b0; tms = 1'b1; tdi = 1'b0; bsr_so = 1'b0;
        @(negedge tck); #(QTR);
        tick(1, 0); tick(0, 1); tick(1, 1);
        check("R2 reset tdo_en", tdo_en, 0);
        check("R2 reset pins_disable", pins_disable, 0);
        check("R2 reset bsr_select", bsr_select, 0);
        trst_n = 1'b1;
        tick(0, 0);
        scan_dr(32, 64'd0, dout, 0);
        check("R2 reset instruction is IDCODE", dout, {32'd0, EXP_ID});

        // Directed decode corners.
        run_code(13'h1FFF, 0);           // R5 all ones
        run_code(13'b1010101010010, 0);  // R5 upper bits ignored, IDCODE
        run_code(13'h0003, 0);           // R9 private code
        run_code(13'h000B, 0);           // R9 HIGHZ
        run_code(13'h0000, 1);           // R8 EXTEST
        run_code(13'h1231, 0);           // R8 SAMPLE

        // R10: tdo_en moves on the falling edge, not the rising one.
        tick(1, 0); tick(0, 0);
        tms = 0;
        @(posedge tck); #(QTR);
        check("R10 tdo_en before falling edge", tdo_en, 0);
        @(negedge tck); #(QTR);
        check("R10 tdo_en after falling edge", tdo_en, 1);
        tick(1, 0); tick(1, 0); tick(0, 0);
        check("R10 tdo_en after scan", tdo_en, 0);

        // R1: five tms-high clocks from inside Shift-IR restore the reset code.
        load_ir(13'h000B, 0, cap);
        check("R9 HIGHZ active", pins_disable, 1);
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 1);
        repeat (5) tick(1, 0);
        check("R1 escape clears HIGHZ", pins_disable, 0);
        tick(0, 0);
        scan_dr(32, 64'd0, dout, 0);
        check("R1 escape restores IDCODE", dout, {32'd0, EXP_ID});

        // R2: trst_n mid-scan.
        load_ir(13'h000B, 0, cap);
        tick(1, 0); tick(0, 0); tick(0, 1);
        trst_n = 1'b0;
        tick(0, 0);
        check("R2 trst_n clears pins_disable", pins_disable, 0);
        check("R2 trst_n clears tdo_en", tdo_en, 0);
        trst_n = 1'b1;
        tick(0, 0);
        scan_dr(32, 64'd0, dout, 0);
        check("R2 trst_n restores IDCODE", dout, {32'd0, EXP_ID});

        // Random codes, half biased to the listed nibbles.
        for (int n = 0; n < 60; n++) begin
            code = 13'($urandom);
            if ($urandom_range(1, 0) == 1) begin
                case ($urandom_range(3, 0))
                    0: code[3:0] = 4'h0;
                    1: code[3:0] = 4'h1;
                    2: code[3:0] = 4'h2;
                    default: code[3:0] = 4'hB;
                endcase
            end
            run_code(code, pins_disable);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge tck);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule